// File: doc/BRIEF.md
# Blitter Control Register Bank

This block is the software-facing register bank of a texture-mapping blitter. It keeps nineteen 32-bit configuration words: the control word, mesh extents, brightness, chroma key, vertex table base, texture and destination buffer bases, resolutions, masks, offsets, square size and alpha. A host reaches them over a simple 32-bit register bus that carries a byte address and byte enables. The word index is the byte address shifted right by two. Only accesses with all four byte enables set are honoured.

Writing the control word with bit 0 set starts the rendering engine, which sits outside this block. A controller then launches the engine with a one-cycle strobe and holds the bank busy. It waits for the engine's done strobe, then drops busy and raises the interrupt for one cycle. While busy is high, the configuration cannot be changed.

The block also flags configuration errors, which are recomputed from the stored values after every write. A brightness or alpha value above 63 is an error. A vertex base that is not 8-byte aligned is an error, and so is a texture base that is not 2-byte aligned. A sticky flag records any read of an offset that has no register.

The controller is a four-state machine:
- IDLE waits for a start write.
- LAUNCH drives the engine start strobe.
- RUN waits for done.
- FINISH raises the interrupt.

Its transitions are:
- IDLE→LAUNCH on an accepted start write.
- LAUNCH→RUN unconditionally.
- RUN→FINISH on done.
- FINISH→LAUNCH on an accepted start write.
- FINISH→IDLE otherwise.

Top module: `blit_regbank`

## Requirements
- R1: After reset, every register reads zero, and `busy`, `irq`, `eng_start`, `chroma_en`, `cfg_err` and `bus_err` are all zero.
- R2: A full write to word offsets 1 to 18 stores the 32-bit value. A read presented in cycle N returns that value on `rd_data` with `rd_valid` high in cycle N+1.
- R3: A full write to offset 0 with bit 0 set, while not busy, raises `eng_start` for exactly one cycle, in the cycle after the write. `busy` goes high in that same cycle, and bit 0 of offset 0 reads 1 while busy.
- R4: When `eng_done` is high while busy, in the next cycle `busy` is low and `irq` is high, and `irq` is high for that one cycle only. Bit 0 of offset 0 then reads 0.
- R5: While busy, writes to every offset, including the control word, are ignored and start nothing.
- R6: Bit 1 of the control word is stored and drives `chroma_en`. A control write with bit 0 clear stores the word without starting the engine.
- R7: `cfg_err[0]` is high while brightness (offset 3) exceeds 63. `cfg_err[1]` is high while alpha (offset 18) exceeds 63.
- R8: `cfg_err[2]` is high while any of bits 2:0 of the vertex base (offset 5) is set. `cfg_err[3]` is high while bit 0 of the texture base (offset 6) is set.
- R9: A read of a word offset of 19 or more returns zero and sets `bus_err`, which stays high until reset. A write to such an offset changes no register.
- R10: An access whose `req_be` is not 4'hF is ignored. Such a write stores nothing and starts nothing, and such a read returns zero.
- R11: `eng_done` while not busy has no effect: no interrupt, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_done | input | 1 | Completion strobe from the engine |
| busy | output | 1 | Operation in flight |
| irq | output | 1 | One-cycle completion interrupt |
| chroma_en | output | 1 | Chroma keying enable (control bit 1) |
| cfg_err | output | 4 | Live configuration error flags |
| bus_err | output | 1 | Sticky unmapped-read flag |

## Verification
The assertions assume that at most one bus request arrives per cycle. They also assume `eng_done` is a single-cycle strobe; it is ignored unless the machine is waiting in RUN. The bench respects both assumptions by driving every input on the falling edge, through tasks that hold a request for exactly one cycle. It raises done only as an isolated one-cycle pulse, either after the launch has been observed or deliberately while idle. Results are sampled on the falling edge that follows the capturing rising edge.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int NREG       = 19;
    localparam int DW         = 32;
    localparam int OFS_CTRL   = 0;
    localparam int OFS_BRIGHT = 3;
    localparam int OFS_VTX    = 5;
    localparam int OFS_TEX    = 6;
    localparam int OFS_ALPHA  = 18;
    localparam int LEVEL_MAX  = 63;
    localparam int ERR_W      = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } blit_state_t;
endpackage

// File: rtl/blit_bus_decode.sv
module blit_bus_decode #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 19,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              wr_hit,
    output logic              rd_req,
    output logic              rd_hit,
    output logic              rd_unmapped
);
    logic is_mapped;
    logic is_full;

    always_comb begin
        sel_idx     = req_addr[ADDR_W-1:2];
        is_mapped   = (sel_idx < IDX_W'(NREG));
        is_full     = (req_be == 4'hF);
        wr_hit      = req_valid && req_write && is_full && is_mapped;
        rd_req      = req_valid && !req_write;
        rd_hit      = rd_req && is_full && is_mapped;
        rd_unmapped = rd_req && !is_mapped;
    end
endmodule

// File: rtl/blit_ctrl_fsm.sv
module blit_ctrl_fsm
    import blit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic eng_done,
    output logic eng_start,
    output logic busy,
    output logic irq
);
    blit_state_t state_q;
    blit_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_RUN;
            ST_RUN:    if (eng_done) state_d = ST_FINISH;
            ST_FINISH: state_d = start_req ? ST_LAUNCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_start = 1'b0;
        busy      = 1'b0;
        irq       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: begin eng_start = 1'b1; busy = 1'b1; end
            ST_RUN:    busy = 1'b1;
            ST_FINISH: irq = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/blit_cfg_store.sv
module blit_cfg_store #(
    parameter int NREG  = 19,
    parameter int DW    = 32,
    parameter int IDX_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     busy_bit,
    output logic [NREG-1:0][DW-1:0]  cfg_view
);
    logic [NREG-1:0][DW-1:0] cfg_q;

    for (genvar i = 0; i < NREG; i++) begin : g_word
        if (i == 0) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[i] <= '0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    cfg_q[i] <= {wr_data[DW-1:1], 1'b0};
            end
            assign cfg_view[i] = {cfg_q[i][DW-1:1], busy_bit};
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[i] <= '0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    cfg_q[i] <= wr_data;
            end
            assign cfg_view[i] = cfg_q[i];
        end
    end
endmodule

// File: rtl/blit_cfg_check.sv
module blit_cfg_check
    import blit_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]    brightness,
    input  logic [DW-1:0]    alpha,
    input  logic [DW-1:0]    vtx_base,
    input  logic [DW-1:0]    tex_base,
    output logic [ERR_W-1:0] cfg_err
);
    always_comb begin
        cfg_err[0] = (brightness > DW'(LEVEL_MAX));
        cfg_err[1] = (alpha > DW'(LEVEL_MAX));
        cfg_err[2] = |vtx_base[2:0];
        cfg_err[3] = tex_base[0];
    end
endmodule

// File: rtl/blit_regbank.sv
module blit_regbank
    import blit_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              eng_start,
    input  logic              eng_done,
    output logic              busy,
    output logic              irq,
    output logic              chroma_en,
    output logic [3:0]        cfg_err,
    output logic              bus_err
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]        sel_idx;
    logic                    wr_hit;
    logic                    rd_req;
    logic                    rd_hit;
    logic                    rd_unmapped;
    logic                    start_req;
    logic [NREG-1:0][DW-1:0] cfg_view;
    logic [DW-1:0]           rd_mux;
    logic                    rd_valid_q;
    logic [DW-1:0]           rd_data_q;
    logic                    bus_err_q;

    blit_bus_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .sel_idx     (sel_idx),
        .wr_hit      (wr_hit),
        .rd_req      (rd_req),
        .rd_hit      (rd_hit),
        .rd_unmapped (rd_unmapped)
    );

    assign start_req = wr_hit && !busy && (sel_idx == IDX_W'(OFS_CTRL)) && req_wdata[0];

    blit_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .eng_done  (eng_done),
        .eng_start (eng_start),
        .busy      (busy),
        .irq       (irq)
    );

    blit_cfg_store #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_hit && !busy),
        .wr_idx   (sel_idx),
        .wr_data  (req_wdata),
        .busy_bit (busy),
        .cfg_view (cfg_view)
    );

    blit_cfg_check #(.DW(DW)) u_chk_cfg (
        .brightness (cfg_view[OFS_BRIGHT]),
        .alpha      (cfg_view[OFS_ALPHA]),
        .vtx_base   (cfg_view[OFS_VTX]),
        .tex_base   (cfg_view[OFS_TEX]),
        .cfg_err    (cfg_err)
    );

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel_idx == IDX_W'(k)) rd_mux = cfg_view[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            bus_err_q  <= 1'b0;
        end else begin
            rd_valid_q <= rd_req;
            rd_data_q  <= rd_hit ? rd_mux : '0;
            if (rd_unmapped) bus_err_q <= 1'b1;
        end
    end

    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign bus_err   = bus_err_q;
    assign chroma_en = cfg_view[OFS_CTRL][1];
endmodule

// File: rtl/blit_regbank_chk.sv
module blit_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic [31:0]       req_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              eng_start,
    input logic              eng_done,
    input logic              busy,
    input logic              irq,
    input logic              chroma_en,
    input logic              bus_err
);
    localparam int IW = ADDR_W - 2;

    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_be == 4'hF && req_addr[ADDR_W-1:2] == '0
         && req_wdata[0] && !busy) |=> (eng_start && busy));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R4
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy && !eng_start) |=> (irq && !busy));

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> busy);

    // R5
    chroma_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(chroma_en));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[ADDR_W-1:2] >= IW'(19))
        |=> (rd_valid && rd_data == 32'h0 && bus_err));

    // R9
    bus_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    // R10
    partial_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_be != 4'hF) |=> !eng_start);

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !busy && !irq) |=> !irq);
endmodule

bind blit_regbank blit_regbank_chk #(.ADDR_W(ADDR_W)) u_regbank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .busy      (busy),
    .irq       (irq),
    .chroma_en (chroma_en),
    .bus_err   (bus_err)
);

// File: tb/blit_regbank_tb.sv
`timescale 1ns/1ps
module blit_regbank_tb;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_be = 4'h0;
    logic [31:0]       req_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              eng_start;
    logic              eng_done = 1'b0;
    logic              busy;
    logic              irq;
    logic              chroma_en;
    logic [3:0]        cfg_err;
    logic              bus_err;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    blit_regbank #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .eng_start(eng_start),
        .eng_done(eng_done), .busy(busy), .irq(irq), .chroma_en(chroma_en),
        .cfg_err(cfg_err), .bus_err(bus_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of request; returns at the falling edge after capture.
    task automatic bus_wr(input int word, input logic [31:0] data, input logic [3:0] be = 4'hF);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(word * 4);
        req_wdata = data; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
    endtask

    task automatic bus_rd(input int word, output logic [31:0] data, input logic [3:0] be = 4'hF);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(word * 4); req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_be = 4'h0;
        if (rd_valid !== 1'b1) begin
            checks++; failures++;
            $display("FAIL R2 rd_valid actual=%b expected=1", rd_valid);
        end
        data = rd_data;
    endtask

    task automatic pulse_done();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 eng_start", {31'b0, eng_start}, 0);
        chk("R1 chroma", {31'b0, chroma_en}, 0);
        chk("R1 cfg_err", {28'b0, cfg_err}, 0);
        chk("R1 bus_err", {31'b0, bus_err}, 0);
        for (int i = 0; i < 19; i++) begin
            bus_rd(i, d);
            chk("R1 reg", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] d;
        for (int i = 1; i < 19; i++) bus_wr(i, pat(i));
        for (int i = 1; i < 19; i++) begin
            bus_rd(i, d);
            chk("R2 readback", d, pat(i));
        end
        for (int i = 1; i < 19; i++) bus_wr(i, 32'h0);
        chk("R2 cfg_err clear", {28'b0, cfg_err}, 0);
    endtask

    task automatic t_start_done();
        logic [31:0] d;
        bus_wr(1, 32'h11);
        bus_wr(0, 32'h3);
        chk("R3 eng_start", {31'b0, eng_start}, 1);
        chk("R3 busy", {31'b0, busy}, 1);
        chk("R6 chroma", {31'b0, chroma_en}, 1);
        @(negedge clk);
        chk("R3 single start", {31'b0, eng_start}, 0);
        bus_rd(0, d);
        chk("R3 ctrl busy bit", d, 32'h3);
        bus_wr(1, 32'h99);
        bus_wr(0, 32'h1);
        chk("R5 no restart", {31'b0, eng_start}, 0);
        bus_rd(1, d);
        chk("R5 write ignored", d, 32'h11);
        chk("R5 chroma kept", {31'b0, chroma_en}, 1);
        pulse_done();
        chk("R4 irq", {31'b0, irq}, 1);
        chk("R4 busy clear", {31'b0, busy}, 0);
        @(negedge clk);
        chk("R4 irq single", {31'b0, irq}, 0);
        bus_rd(0, d);
        chk("R4 ctrl after", d, 32'h2);
    endtask

    task automatic t_ctrl_no_start();
        bus_wr(0, 32'h0);
        chk("R6 chroma off", {31'b0, chroma_en}, 0);
        bus_wr(0, 32'h2);
        chk("R6 no start", {31'b0, eng_start}, 0);
        chk("R6 no busy", {31'b0, busy}, 0);
        chk("R6 chroma on", {31'b0, chroma_en}, 1);
        bus_wr(0, 32'h0);
    endtask

    task automatic t_errors();
        bus_wr(3, 32'd64);  chk("R7 bright err", {28'b0, cfg_err}, 32'h1);
        bus_wr(3, 32'd63);  chk("R7 bright ok", {28'b0, cfg_err}, 32'h0);
        bus_wr(18, 32'd64); chk("R7 alpha err", {28'b0, cfg_err}, 32'h2);
        bus_wr(18, 32'd63); chk("R7 alpha ok", {28'b0, cfg_err}, 32'h0);
        bus_wr(5, 32'h104); chk("R8 vtx err", {28'b0, cfg_err}, 32'h4);
        bus_wr(5, 32'h108); chk("R8 vtx ok", {28'b0, cfg_err}, 32'h0);
        bus_wr(6, 32'h11);  chk("R8 tex err", {28'b0, cfg_err}, 32'h8);
        bus_wr(6, 32'h10);  chk("R8 tex ok", {28'b0, cfg_err}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_wr(1, 32'h55);
        bus_wr(19, 32'hFFFF_FFFF);
        bus_wr(63, 32'hFFFF_FFFF);
        chk("R9 no err on write", {31'b0, bus_err}, 0);
        bus_rd(1, d);
        chk("R9 write ignored", d, 32'h55);
        bus_rd(19, d);
        chk("R9 read zero", d, 0);
        chk("R9 bus_err", {31'b0, bus_err}, 1);
        @(negedge clk); @(negedge clk);
        chk("R9 sticky", {31'b0, bus_err}, 1);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        bus_wr(2, 32'h77);
        bus_wr(2, 32'hDEAD_BEEF, 4'h3);
        bus_rd(2, d);
        chk("R10 partial write", d, 32'h77);
        bus_rd(2, d, 4'h1);
        chk("R10 partial read", d, 0);
        bus_wr(0, 32'h3, 4'h7);
        chk("R10 no start", {31'b0, eng_start}, 0);
        chk("R10 no busy", {31'b0, busy}, 0);
    endtask

    task automatic t_idle_done();
        pulse_done();
        chk("R11 no irq", {31'b0, irq}, 0);
        chk("R11 busy low", {31'b0, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_start_done();
        t_ctrl_no_start();
        t_errors();
        t_unmapped();
        t_partial();
        t_idle_done();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule